// File: doc/BRIEF.md
# Banked GPIO Controller with Masked Writes

This block is a memory-mapped general-purpose I/O controller. Pins are grouped in banks of eight, and every bank has a small register set on a 32-bit register bus. A per-pin configuration bit decides who owns each pad. When the bit is set, the controller's own output and output-enable bits drive the pad. When it is clear, the special-function path of that pin drives the pad.

Software can change one pin without a read-modify-write sequence. Each bank has two aliases, one for the output register and one for the output-enable register. A write to an alias carries a per-pin write mask in bits [15:8] and the new pin values in bits [7:0]. Pad levels are brought into the clock domain through a two-flop synchronizer before they can be read. Read data is registered and appears one clock after the address.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset, every configuration, output-enable and output bit is 0. Every pad then follows its special-function inputs (pad_out = sf_out, pad_oe = sf_oe).
- R2: Bank k decodes at byte base (k/4)*0x100 + (k%4)*4. Registers sit at these offsets from the base: configuration 0x00, output enable 0x10, output 0x20, input 0x30, masked output enable 0x50, masked output 0x60. Read data for the address presented in one cycle appears on bus_rdata after the next rising edge. Pin p is bit p of [7:0], and bits [31:8] read 0.
- R3: A plain write to the configuration, output-enable or output register replaces all eight bits with bus_wdata[7:0].
- R4: A write to a masked alias (0x50 for output enable, 0x60 for output) updates pin p to bus_wdata[p] only when bus_wdata[p+8] is 1. Every other pin keeps its value.
- R5: The masked aliases read as 0. A write to the input register changes nothing.
- R6: For a pin whose configuration bit is 1, pad_out and pad_oe carry the GPIO output and output-enable bits. For a pin whose configuration bit is 0, they carry sf_out and sf_oe.
- R7: The input register returns pad_in through two flops. A read whose address is presented in the cycle that ends at edge e returns the pad level sampled at edge e-2.
- R8: The output register reads back the last value written to it, whatever the pin's direction or configuration.
- R9: These addresses are unmapped: a register offset of 0x40 or 0x70–0xF0, an address with bits [1:0] non-zero, or a bank index of NUM_BANKS or more. They read 0, and writes to them change no register.
- R10: Flat pin index i maps to bank i>>3 and pin i&7. Pad vector bit i belongs to that bank and pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data; mask in [15:8] and values in [7:0] for the masked aliases |
| bus_rdata | output | 32 | Registered read data, one cycle after the address |
| sf_out | input | NUM_BANKS*8 | Special-function output value for each pin |
| sf_oe | input | NUM_BANKS*8 | Special-function output enable for each pin |
| pad_in | input | NUM_BANKS*8 | Asynchronous pad levels |
| pad_out | output | NUM_BANKS*8 | Value driven to each pad |
| pad_oe | output | NUM_BANKS*8 | Driver enable for each pad (1 = drive) |

## Verification
The bench sweeps all 256 mask values on both masked aliases in every bank. A design that swapped the mask and value bytes, or left unmasked pins unprotected, would corrupt neighbouring pins within the first few masks. Each bank is loaded with a distinct pattern and every bank is read back, so a wrong base formula for banks past the first group of four would alias banks onto each other. The synchronizer is checked cycle by cycle: one flop too few or too many shifts the edge at which the new level appears. Writes to unmapped addresses, to the input register and to the aliases are followed by a read-back of all banks, which exposes a decode that lets a stray write land in a real register.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int PINS_PER_BANK = 8;

    // register select field, address bits [7:4]
    localparam logic [3:0] SEL_CFG  = 4'h0;
    localparam logic [3:0] SEL_OE   = 4'h1;
    localparam logic [3:0] SEL_OUT  = 4'h2;
    localparam logic [3:0] SEL_IN   = 4'h3;
    localparam logic [3:0] SEL_MOE  = 4'h5;
    localparam logic [3:0] SEL_MOUT = 4'h6;

    typedef logic [PINS_PER_BANK-1:0] pin_vec_t;

    typedef struct packed {
        pin_vec_t cfg;
        pin_vec_t oe;
        pin_vec_t out;
    } bank_state_t;

    typedef struct packed {
        logic [31:0] rdata;
    } ctrl_state_t;

    function automatic pin_vec_t masked_merge(pin_vec_t old_v, pin_vec_t mask, pin_vec_t new_v);
        return (old_v & ~mask) | (new_v & mask);
    endfunction

    function automatic logic sel_known(logic [3:0] sel);
        return (sel == SEL_CFG) || (sel == SEL_OE) || (sel == SEL_OUT) ||
               (sel == SEL_IN)  || (sel == SEL_MOE) || (sel == SEL_MOUT);
    endfunction

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_bank_pkg::*;
#(
    parameter int NUM_BANKS = 31,
    parameter int ADDR_W    = 12
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic [ADDR_W-7:0]   bank_idx,
    output logic [3:0]          reg_sel,
    output logic                hit
);
    localparam int BANK_W = ADDR_W - 6;

    logic in_range;

    // bank = group (addr above bit 7) * 4 + slot (addr[3:2])
    assign bank_idx = {addr[ADDR_W-1:8], addr[3:2]};
    assign reg_sel  = addr[7:4];
    assign in_range = ({1'b0, bank_idx} < (BANK_W+1)'(NUM_BANKS));
    assign hit      = (addr[1:0] == 2'b00) && in_range && sel_known(reg_sel);

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    typedef struct packed {
        logic [WIDTH-1:0] s1;
        logic [WIDTH-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = async_in;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q.s2;

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
    import gpio_bank_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [3:0]  reg_sel,
    input  logic [15:0] wdata,
    input  pin_vec_t    in_lvl,
    output pin_vec_t    cfg,
    output pin_vec_t    oe,
    output pin_vec_t    out,
    output pin_vec_t    rd_word
);
    bank_state_t st_d, st_q;
    pin_vec_t    wr_mask;
    pin_vec_t    wr_val;

    assign wr_mask = wdata[15:8];
    assign wr_val  = wdata[7:0];

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (reg_sel)
                SEL_CFG:  st_d.cfg = wr_val;
                SEL_OE:   st_d.oe  = wr_val;
                SEL_OUT:  st_d.out = wr_val;
                SEL_MOE:  st_d.oe  = masked_merge(st_q.oe,  wr_mask, wr_val);
                SEL_MOUT: st_d.out = masked_merge(st_q.out, wr_mask, wr_val);
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (reg_sel)
            SEL_CFG: rd_word = st_q.cfg;
            SEL_OE:  rd_word = st_q.oe;
            SEL_OUT: rd_word = st_q.out;
            SEL_IN:  rd_word = in_lvl;
            default: rd_word = '0;
        endcase
    end

    assign cfg = st_q.cfg;
    assign oe  = st_q.oe;
    assign out = st_q.out;

endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
    parameter int NPINS = 8
) (
    input  logic [NPINS-1:0] cfg,
    input  logic [NPINS-1:0] gp_out,
    input  logic [NPINS-1:0] gp_oe,
    input  logic [NPINS-1:0] sf_out,
    input  logic [NPINS-1:0] sf_oe,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_oe
);
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        assign pad_out[i] = cfg[i] ? gp_out[i] : sf_out[i];
        assign pad_oe[i]  = cfg[i] ? gp_oe[i]  : sf_oe[i];
    end

endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpio_bank_pkg::*;
#(
    parameter int NUM_BANKS = 31,
    parameter int ADDR_W    = 12
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [ADDR_W-1:0]                  bus_addr,
    input  logic                               bus_we,
    input  logic [31:0]                        bus_wdata,
    output logic [31:0]                        bus_rdata,
    input  logic [NUM_BANKS*PINS_PER_BANK-1:0] sf_out,
    input  logic [NUM_BANKS*PINS_PER_BANK-1:0] sf_oe,
    input  logic [NUM_BANKS*PINS_PER_BANK-1:0] pad_in,
    output logic [NUM_BANKS*PINS_PER_BANK-1:0] pad_out,
    output logic [NUM_BANKS*PINS_PER_BANK-1:0] pad_oe
);
    localparam int NPINS  = NUM_BANKS * PINS_PER_BANK;
    localparam int BANK_W = ADDR_W - 6;

    logic [BANK_W-1:0] dec_bank;
    logic [3:0]        dec_reg;
    logic              dec_hit;
    logic [NPINS-1:0]  in_sync;
    logic [NPINS-1:0]  cfg_all;
    logic [NPINS-1:0]  oe_all;
    logic [NPINS-1:0]  out_all;
    pin_vec_t          bank_rd [NUM_BANKS];
    logic              unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[31:16];

    gpio_addr_decode #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_dec (
        .addr     (bus_addr),
        .bank_idx (dec_bank),
        .reg_sel  (dec_reg),
        .hit      (dec_hit)
    );

    gpio_in_sync #(.WIDTH(NPINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (in_sync)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic bank_wr;
        assign bank_wr = bus_we && dec_hit && (dec_bank == BANK_W'(b));

        gpio_bank_regs u_regs (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (bank_wr),
            .reg_sel (dec_reg),
            .wdata   (bus_wdata[15:0]),
            .in_lvl  (in_sync[b*PINS_PER_BANK +: PINS_PER_BANK]),
            .cfg     (cfg_all[b*PINS_PER_BANK +: PINS_PER_BANK]),
            .oe      (oe_all[b*PINS_PER_BANK +: PINS_PER_BANK]),
            .out     (out_all[b*PINS_PER_BANK +: PINS_PER_BANK]),
            .rd_word (bank_rd[b])
        );
    end

    gpio_pad_mux #(.NPINS(NPINS)) u_mux (
        .cfg     (cfg_all),
        .gp_out  (out_all),
        .gp_oe   (oe_all),
        .sf_out  (sf_out),
        .sf_oe   (sf_oe),
        .pad_out (pad_out),
        .pad_oe  (pad_oe)
    );

    ctrl_state_t st_d, st_q;

    always_comb begin
        st_d.rdata = '0;
        if (dec_hit) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (dec_bank == BANK_W'(b)) st_d.rdata = {24'd0, bank_rd[b]};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;

endmodule

// File: rtl/gpio_bank_ctrl_sva.sv
module gpio_bank_ctrl_sva #(
    parameter int NUM_BANKS = 31,
    parameter int ADDR_W    = 12
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [ADDR_W-1:0]      bus_addr,
    input logic [31:0]            bus_rdata,
    input logic [NUM_BANKS*8-1:0] sf_out,
    input logic [NUM_BANKS*8-1:0] sf_oe,
    input logic [NUM_BANKS*8-1:0] pad_in,
    input logic [NUM_BANKS*8-1:0] pad_out,
    input logic [NUM_BANKS*8-1:0] pad_oe,
    input logic [NUM_BANKS*8-1:0] cfg_all,
    input logic [NUM_BANKS*8-1:0] in_sync
);
    logic [1:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R1: first cycle out of reset has no pin under GPIO ownership
    assert_reset_cfg_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd0) |-> (cfg_all == '0));

    // R2: upper read bits stay zero
    assert_rdata_hi_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[31:8] == 24'd0);

    // R5: alias reads give zero
    assert_alias_read_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 2'd0 && (bus_addr[7:4] == 4'h5 || bus_addr[7:4] == 4'h6))
        |=> (bus_rdata == 32'd0));

    // R9: unmapped register offsets read zero
    assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 2'd0 && (bus_addr[7:4] == 4'h4 || bus_addr[7:4] >= 4'h7 || bus_addr[1:0] != 2'b00))
        |=> (bus_rdata == 32'd0));

    // R6: pins not under GPIO follow the special-function path
    assert_sf_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((((pad_out ^ sf_out) | (pad_oe ^ sf_oe)) & ~cfg_all) == '0));

    // R7: two-flop latency from pad to input register
    assert_sync_depth_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3) |-> (in_sync == $past(pad_in, 2)));

endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_sva #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .sf_out    (sf_out),
    .sf_oe     (sf_oe),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .cfg_all   (cfg_all),
    .in_sync   (in_sync)
);

// File: tb/gpio_bank_ctrl_bench.sv
module gpio_bank_ctrl_bench;
    localparam int NB = 5;
    localparam int AW = 12;
    localparam int NP = NB * 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] sf_out = 40'hA5_5A_C3_3C_96;
    logic [NP-1:0] sf_oe  = 40'h0F_F0_3C_C3_69;
    logic [NP-1:0] pad_in = 40'h12_34_56_78_9A;
    logic [NP-1:0] pad_out, pad_oe;

    always #10 clk = ~clk;

    gpio_bank_ctrl #(.NUM_BANKS(NB), .ADDR_W(AW)) u_gpio_bank_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sf_out(sf_out),
        .sf_oe(sf_oe), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [7:0] m_cfg [NB];
    logic [7:0] m_oe  [NB];
    logic [7:0] m_out [NB];

    function automatic int raddr(int b, int sel);
        return (b / 4) * 256 + (b % 4) * 4 + sel * 16;
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        bus_addr = AW'(a); bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(int a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = AW'(a); bus_we = 1'b0;
        @(negedge clk);
        v = bus_rdata;
    endtask

    task automatic check_all_banks(string req);
        logic [31:0] v;
        for (int b = 0; b < NB; b++) begin
            rd(raddr(b, 0), v); chk({req, " cfg"}, 64'(v), 64'(m_cfg[b]));
            rd(raddr(b, 1), v); chk({req, " oe"},  64'(v), 64'(m_oe[b]));
            rd(raddr(b, 2), v); chk({req, " out"}, 64'(v), 64'(m_out[b]));
        end
    endtask

    task automatic check_pads(string req);
        logic [NP-1:0] eo, ee;
        for (int i = 0; i < NP; i++) begin
            eo[i] = m_cfg[i >> 3][i & 7] ? m_out[i >> 3][i & 7] : sf_out[i];
            ee[i] = m_cfg[i >> 3][i & 7] ? m_oe[i >> 3][i & 7]  : sf_oe[i];
        end
        #1;
        chk({req, " pad_out"}, 64'(pad_out), 64'(eo));
        chk({req, " pad_oe"},  64'(pad_oe),  64'(ee));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [7:0]  mv;
        for (int b = 0; b < NB; b++) begin m_cfg[b] = 0; m_oe[b] = 0; m_out[b] = 0; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check_all_banks("R1");
        check_pads("R1");

        // R2 R3 R10: distinct full writes per bank, all banks read back
        for (int b = 0; b < NB; b++) begin
            m_cfg[b] = 8'(8'h3C ^ (b * 8'h27));
            m_oe[b]  = 8'(8'hA6 ^ (b * 8'h13));
            m_out[b] = 8'(8'h51 ^ (b * 8'h6B));
            wr(raddr(b, 0), {16'hFFFF, 8'h00, m_cfg[b]});
            wr(raddr(b, 1), {24'h00FF00, m_oe[b]});
            wr(raddr(b, 2), {24'h0, m_out[b]});
        end
        check_all_banks("R2_R3");
        check_pads("R6_R10");

        // R4: mask sweep on both aliases of every bank
        for (int b = 0; b < NB; b++) begin
            for (int m = 0; m < 256; m++) begin
                mv = 8'((m * 7) ^ 8'h5A ^ b);
                wr(raddr(b, 6), {16'h0, 8'(m), mv});
                m_out[b] = (m_out[b] & ~8'(m)) | (mv & 8'(m));
                rd(raddr(b, 2), v); chk("R4 masked out", 64'(v), 64'(m_out[b]));
                wr(raddr(b, 5), {16'h0, 8'(m), ~mv});
                m_oe[b] = (m_oe[b] & ~8'(m)) | (~mv & 8'(m));
                rd(raddr(b, 1), v); chk("R4 masked oe", 64'(v), 64'(m_oe[b]));
            end
        end
        check_all_banks("R4 neighbours");
        check_pads("R6 after sweep");

        // R5: aliases read zero, input register ignores writes
        rd(raddr(2, 5), v); chk("R5 alias oe read", 64'(v), 64'd0);
        rd(raddr(3, 6), v); chk("R5 alias out read", 64'(v), 64'd0);
        wr(raddr(1, 3), 32'h0000_FFFF);
        rd(raddr(1, 3), v); chk("R5 input write ignored", 64'(v), 64'(pad_in[15:8]));
        check_all_banks("R5");

        // R8: output readback with pin as input and special-function
        wr(raddr(4, 0), 32'h0); m_cfg[4] = 0;
        wr(raddr(4, 1), 32'h0); m_oe[4] = 0;
        wr(raddr(4, 2), 32'hC9); m_out[4] = 8'hC9;
        rd(raddr(4, 2), v); chk("R8 out readback", 64'(v), 64'hC9);
        check_pads("R8_R6");

        // R7: synchronizer latency
        for (int b = 0; b < NB; b++) begin
            rd(raddr(b, 3), v); chk("R7 input level", 64'(v), 64'(pad_in[b*8 +: 8]));
        end
        @(negedge clk);
        pad_in[7:0] = 8'h5E;
        bus_addr = AW'(raddr(0, 3));
        @(negedge clk); chk("R7 edge1 old", 64'(bus_rdata), 64'h9A);
        @(negedge clk); chk("R7 edge2 old", 64'(bus_rdata), 64'h9A);
        @(negedge clk); chk("R7 edge3 new", 64'(bus_rdata), 64'h5E);

        // R9: unmapped addresses
        rd(12'h040, v); chk("R9 offset 0x40", 64'(v), 64'd0);
        rd(12'h070, v); chk("R9 offset 0x70", 64'(v), 64'd0);
        rd(12'h104 + 12'h020, v); chk("R9 bank past end", 64'(v), 64'd0);
        rd(12'h222, v); chk("R9 misaligned", 64'(v), 64'd0);
        rd(12'hF00, v); chk("R9 high group", 64'(v), 64'd0);
        wr(12'h040, 32'h0000_FFFF);
        wr(12'h0F8, 32'h0000_FFFF);
        wr(12'h104, 32'h0000_FFFF);
        wr(12'h124, 32'h0000_FFFF);
        wr(12'h021, 32'h0000_FFFF);
        wr(12'h302, 32'h0000_FFFF);
        check_all_banks("R9 no effect");
        check_pads("R9 pads");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule